// File: doc/BRIEF.md
# Page Load Buffer with Wrapping Offset

This block sits behind a serial write slave and collects one page of write data before anything reaches the memory array. The slave first presents a start address with a load strobe. The upper address bits select a page, and that page stays fixed for the rest of the transfer. The lower five bits give the starting byte offset. Each data strobe then stores one byte at the current offset and moves the offset forward by one. The offset wraps from 31 back to 0 inside the same 32-byte page, so a long transfer overwrites earlier bytes in the order they arrived.

A 32-bit mask records which offsets were loaded since the last address load. A commit strobe starts a timed write cycle that lasts a parameterized number of clocks, and the busy output stays high for that whole cycle. During the first 32 clocks of the cycle the block steps through the offsets in ascending order. It sends one array write for each offset whose mask bit is set and skips every offset whose bit is clear. Strobes that arrive while busy is high are dropped.

Top module: `page_load_buf`

## Requirements
- R1: After reset, busy_o and mem_we_o are low, the page and offset are 0, and no offset is marked as loaded, so a commit issued straight after reset produces no array writes.
- R2: An address load while idle sets the page to addr_i[ADDR_W-1:5] and the offset to addr_i[4:0], and clears every loaded mark, so bytes accepted before that load are never written.
- R3: Each data strobe while idle stores data_i at the current offset, marks that offset as loaded, and advances the offset by one. The page is left unchanged.
- R4: Offsets wrap from 31 to 0 within the page. Thirty-two bytes loaded from offset 16 land on offsets 16..31 and then 0..15, and the next byte goes to offset 16 again.
- R5: When more than 32 bytes are sent, each later byte replaces the byte already held at its offset, and the commit carries only the latest value for each offset.
- R6: A commit strobe while idle raises busy_o from the next clock for exactly WR_CYCLES clocks (WR_CYCLES at least 32), after which busy_o falls.
- R7: During the write cycle, mem_we_o pulses once for each loaded offset, in ascending offset order, within the first 32 busy clocks. mem_addr_o is {page, offset} and mem_data_o is the latest byte for that offset. Offsets that were not loaded are never written.
- R8: Address-load, data and commit strobes that arrive while busy_o is high have no effect. The page, the offset, the stored bytes, the loaded marks and the cycle length all stay as they were.
- R9: A commit with no loaded offsets still runs the full busy cycle but issues no array writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load_i | input | 1 | Strobe: load page and start offset from addr_i |
| addr_i | input | ADDR_W | Start address; upper bits give the page, low 5 bits the offset |
| data_vld_i | input | 1 | Strobe: accept data_i at the current offset |
| data_i | input | 8 | Data byte |
| commit_i | input | 1 | Strobe: start the timed write cycle |
| busy_o | output | 1 | High for the whole write cycle |
| mem_we_o | output | 1 | Array write enable, one clock per written byte |
| mem_addr_o | output | ADDR_W | Array write address {page, offset} |
| mem_data_o | output | 8 | Array write data |

## Verification
The page is loaded in several ways, and each way tests a different part of the behaviour. A short run from a mid-page offset checks plain storage and increment. A full 32-byte run from offset 16, followed by one extra byte, shows whether the pointer wraps and comes back to its start. A 40-byte run from offset 30 shows whether later bytes replace earlier ones. An address load that follows a partial run shows whether the mask is cleared. A commit with nothing loaded checks that the cycle still runs and writes nothing. A final pattern injects every strobe in mid-cycle and on the last busy clock, then repeats the commit to show that neither the buffer, the pointer nor the cycle length changed.

// File: rtl/plb_pkg.sv
package plb_pkg;
    localparam int PAGE_BYTES = 32;
    localparam int OFF_W      = $clog2(PAGE_BYTES);

    typedef logic [7:0] byte_t;

    // one accepted action per clock, already gated by busy
    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_ADDR   = 2'd1,
        CMD_DATA   = 2'd2,
        CMD_COMMIT = 2'd3
    } cmd_e;
endpackage

// File: rtl/plb_ptr.sv
module plb_ptr
    import plb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  cmd_e                    cmd,
    input  logic [ADDR_W-1:0]       addr,
    output logic [ADDR_W-OFF_W-1:0] page,
    output logic [OFF_W-1:0]        off
);
    localparam int PG_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_ADDR: begin
                st_d.page = addr[ADDR_W-1:OFF_W];
                st_d.off  = addr[OFF_W-1:0];
            end
            CMD_DATA: st_d.off = st_q.off + 1'b1; // wraps inside the page
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign page = st_q.page;
    assign off  = st_q.off;
endmodule

// File: rtl/plb_store.sv
module plb_store
    import plb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  cmd_e                  cmd,
    input  logic [OFF_W-1:0]      wr_off,
    input  byte_t                 wr_data,
    input  logic [OFF_W-1:0]      rd_off,
    output byte_t                 rd_data,
    output logic [PAGE_BYTES-1:0] mask
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] bytes;
        logic [PAGE_BYTES-1:0]      mask;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_ADDR: st_d.mask = '0;
            CMD_DATA: begin
                st_d.bytes[wr_off] = wr_data;
                st_d.mask[wr_off]  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.bytes[rd_off];
    assign mask    = st_q.mask;
endmodule

// File: rtl/plb_wcycle.sv
module plb_wcycle
    import plb_pkg::*;
#(
    parameter int WR_CYCLES = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cmd_e                  cmd,
    input  logic [PAGE_BYTES-1:0] mask,
    output logic                  busy,
    output logic [OFF_W-1:0]      scan_off,
    output logic                  scan_we
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } wc_t;

    wc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (cmd == CMD_COMMIT) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
            end
        end else if (st_q.cnt == LAST) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign scan_off = st_q.cnt[OFF_W-1:0];
    assign scan_we  = st_q.busy && (st_q.cnt < SCAN_END) && mask[scan_off];
endmodule

// File: rtl/page_load_buf.sv
module page_load_buf
    import plb_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int WR_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_vld_i,
    input  logic [7:0]        data_i,
    input  logic              commit_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o
);
    localparam int PG_W = ADDR_W - OFF_W;

    cmd_e                  cmd;
    logic [PG_W-1:0]       page;
    logic [OFF_W-1:0]      off;
    logic [OFF_W-1:0]      scan_off;
    logic [PAGE_BYTES-1:0] mask;
    byte_t                 rd_data;
    logic                  busy;
    logic                  scan_we;

    // strobes are dropped while busy; commit wins over address, address over data
    always_comb begin
        cmd = CMD_NONE;
        if (!busy) begin
            if      (commit_i)    cmd = CMD_COMMIT;
            else if (addr_load_i) cmd = CMD_ADDR;
            else if (data_vld_i)  cmd = CMD_DATA;
        end
    end

    plb_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .addr  (addr_i),
        .page  (page),
        .off   (off)
    );

    plb_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .wr_off  (off),
        .wr_data (data_i),
        .rd_off  (scan_off),
        .rd_data (rd_data),
        .mask    (mask)
    );

    plb_wcycle #(.WR_CYCLES(WR_CYCLES)) u_wcycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .mask     (mask),
        .busy     (busy),
        .scan_off (scan_off),
        .scan_we  (scan_we)
    );

    assign busy_o     = busy;
    assign mem_we_o   = scan_we;
    assign mem_addr_o = {page, scan_off};
    assign mem_data_o = rd_data;
endmodule

// File: rtl/page_load_buf_chk.sv
module page_load_buf_chk #(
    parameter int ADDR_W    = 12,
    parameter int WR_CYCLES = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_i,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else             run_q <= 0;
    end

    AST_WE_INSIDE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R7
    AST_COMMIT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !busy_o) |=> busy_o); // R6
    AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == WR_CYCLES)); // R6
    AST_CYCLE_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < WR_CYCLES)); // R8
    AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mem_addr_o[ADDR_W-1:5])); // R8
    AST_WE_IN_SCAN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (run_q < 32)); // R7
endmodule

bind page_load_buf page_load_buf_chk #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit_i),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/page_load_buf_tb_top.sv
module page_load_buf_tb_top;
    localparam int ADDR_W = 12;
    localparam int WR_CYC = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              addr_load_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              data_vld_i = 1'b0;
    logic [7:0]        data_i = '0;
    logic              commit_i = 1'b0;
    logic              busy_o;
    logic              mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [7:0]        mem_data_o;

    always #5 clk = ~clk;

    page_load_buf #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_load_i(addr_load_i), .addr_i(addr_i),
        .data_vld_i(data_vld_i), .data_i(data_i), .commit_i(commit_i),
        .busy_o(busy_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model of the page
    logic [7:0]        m_buf [32];
    logic [31:0]       m_mask = '0;
    logic [ADDR_W-6:0] m_page = '0;
    logic [4:0]        m_off = '0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic load_addr(logic [ADDR_W-1:0] a);
        @(negedge clk); addr_load_i = 1'b1; addr_i = a;
        @(negedge clk); addr_load_i = 1'b0;
        m_page = a[ADDR_W-1:5]; m_off = a[4:0]; m_mask = '0;
    endtask

    task automatic send_byte(logic [7:0] d);
        @(negedge clk); data_vld_i = 1'b1; data_i = d;
        @(negedge clk); data_vld_i = 1'b0;
        m_buf[m_off] = d; m_mask[m_off] = 1'b1; m_off = m_off + 5'd1;
    endtask

    // commit and compare the write stream against the model; optional
    // injection of every strobe while busy
    task automatic run_commit(string tag, bit inject);
        int exp_addr [32];
        int exp_data [32];
        int n_exp = 0;
        int n_got = 0;
        int n_busy = 0;
        for (int o = 0; o < 32; o++) begin
            if (m_mask[o]) begin
                exp_addr[n_exp] = int'({m_page, 5'(o)});
                exp_data[n_exp] = int'(m_buf[o]);
                n_exp++;
            end
        end
        @(negedge clk); commit_i = 1'b1;
        @(negedge clk); commit_i = 1'b0;
        while (busy_o && n_busy < WR_CYC + 8) begin
            n_busy++;
            if (mem_we_o) begin
                if (n_got < n_exp) begin
                    chk(tag, "write address", int'(mem_addr_o), exp_addr[n_got]);
                    chk(tag, "write data", int'(mem_data_o), exp_data[n_got]);
                end
                n_got++;
            end
            if (inject) begin
                if (n_busy == 3) begin
                    addr_load_i = 1'b1; addr_i = 12'hFFF;
                    data_vld_i = 1'b1; data_i = 8'hEE; commit_i = 1'b1;
                end else if (n_busy == 4) begin
                    addr_load_i = 1'b0; data_vld_i = 1'b0; commit_i = 1'b0;
                end else if (n_busy == 5) begin
                    data_vld_i = 1'b1; data_i = 8'hDD;
                end else if (n_busy == 6) begin
                    data_vld_i = 1'b0;
                end else if (n_busy == WR_CYC) begin
                    commit_i = 1'b1;
                end
            end
            @(negedge clk);
        end
        commit_i = 1'b0;
        chk(tag, "busy length", n_busy, WR_CYC);
        chk(tag, "write count", n_got, n_exp);
        @(negedge clk);
        chk(tag, "busy low after cycle", int'(busy_o), 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy after reset", int'(busy_o), 0);
        chk("R1", "we after reset", int'(mem_we_o), 0);
        run_commit("R1", 1'b0);
    endtask

    task automatic t_basic();
        load_addr(12'h123);
        for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
        run_commit("R3", 1'b0);
    endtask

    task automatic t_wrap();
        load_addr(12'h2B0);
        for (int i = 0; i < 32; i++) send_byte(8'h40 + 8'(i));
        run_commit("R4", 1'b0);
        send_byte(8'h5E); // must land at offset 16
        chk("R4", "model pointer after 33 bytes", int'(m_off), 17);
        run_commit("R4", 1'b0);
    endtask

    task automatic t_overwrite();
        load_addr(12'h07E);
        for (int i = 0; i < 40; i++) send_byte(8'h80 + 8'(i));
        run_commit("R5", 1'b0);
    endtask

    task automatic t_reload();
        load_addr(12'h345);
        send_byte(8'hA1);
        send_byte(8'hA2);
        load_addr(12'h3E9);
        send_byte(8'hB7);
        run_commit("R2", 1'b0);
    endtask

    task automatic t_busy_ignore();
        load_addr(12'h51C);
        for (int i = 0; i < 6; i++) send_byte(8'hC0 + 8'(i));
        run_commit("R8", 1'b1);
        run_commit("R8", 1'b0);
        send_byte(8'h3C); // pointer kept at offset 0x1C+6 = 2
        run_commit("R8", 1'b0);
    endtask

    task automatic t_empty();
        load_addr(12'h600);
        run_commit("R9", 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wrap();
        t_overwrite();
        t_reload();
        t_busy_ignore();
        t_empty();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end
endmodule